// File: doc/BRIEF.md
# Three-Symbol Multiuser Window Buffer

This buffer sits between two filtering stages of a multiuser receiver. The first stage produces one real-valued result per user per symbol, and it works through the users one at a time. The second stage needs, for each symbol n, a single vector of 3K values. That vector holds all K users at symbol n-1, then all K users at symbol n, then all K users at symbol n+1. The buffer collects the first-stage results in any user order and presents that vector through an element-indexed read port. Because of the buffer, the two stages can run at different rates.

Storage is a circular bank of four symbol slots, each holding K entries. Slot choice is the low two bits of the symbol index. The window for symbol n becomes valid once symbols n and n+1 are complete for every user. This gives one symbol of look-ahead latency. The consumer releases a window with a valid/ready handshake: `win_valid` is the valid and `win_ack` is the ready. Releasing the window for n frees the slot of n-1, so that symbol n+3 can then be written.

The write side is also a valid/ready stream. `wr_ready` depends only on the write symbol, the write user and internal state; it never depends on `wr_valid`. A write that would land on a slot still in use is held back. The producer must keep `wr_valid` and the data stable until `wr_ready` is high, and `wr_stall` flags each cycle in which a write is waiting. A `flush` pulse marks the end of a frame. After it, the remaining windows are released with zeros in place of the missing look-ahead symbol, and the buffer then returns to the start of a new frame.

Top module: `symwin_buf`

## Requirements
- R1: After reset `win_valid` is 0, `win_sym` is 0, `wr_stall` is 0, and `wr_ready` is 1 for symbol 0 and user 0.
- R2: With current symbol n, a write is accepted (`wr_ready`=1) only when not draining, the user is below K, and the symbol is n, n+1, n+2, or n-1 when n is not 0. A write for any other symbol keeps `wr_ready` at 0, and `wr_stall` is 1 while `wr_valid` is held. An accepted late write for n-1 is visible in the window.
- R3: Outside drain mode, `win_valid` is 1 exactly when every user has been written for both symbol `win_sym` and symbol `win_sym`+1.
- R4: `rd_data` follows `rd_idx` in the same cycle. Index i below K gives user i at n-1. Index K+i gives user i at n. Index 2K+i gives user i at n+1.
- R5: While `win_sym` is 0 (the first symbol of a frame), indices 0 to K-1 read 0.
- R6: `win_valid` and `win_ack` high in one cycle move `win_sym` to n+1 on the next edge. `win_ack` while `win_valid` is 0 has no effect.
- R7: A `flush` pulse enters drain mode. `wr_ready` is then 0, the window for n is valid once n is complete, and entries for an incomplete n+1 read 0.
- R8: Releasing a window in drain mode while n+1 is incomplete returns the buffer to frame start: `win_sym` is 0, all slots are empty, and writes are accepted again.
- R9: An `rd_idx` of 3K or more reads 0.
- R10: A write and a window release in the same cycle both take effect. The write is judged against the symbol held before the release.
- R11: Writing a user and symbol that are already stored replaces the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write item valid |
| wr_ready | output | 1 | Write item can be taken this cycle |
| wr_user | input | USER_W | User index of the write |
| wr_sym | input | SYM_W | Symbol index of the write (modulo 2^SYM_W) |
| wr_data | input | DATA_W | Signed first-stage result |
| wr_stall | output | 1 | A valid write is being held back |
| flush | input | 1 | End-of-frame pulse, enters drain mode |
| win_valid | output | 1 | Window for `win_sym` is readable |
| win_ack | input | 1 | Consumer releases the current window |
| win_sym | output | SYM_W | Current window symbol n |
| rd_idx | input | IDX_W | Element index into the 3K vector |
| rd_data | output | DATA_W | Selected element, zero when absent |

## Verification
A write and a window release can fall in the same cycle. The bench drives `wr_valid` with symbol n+2 and `win_ack` on the same edge. It then checks three things: the write was accepted against the old symbol, `win_sym` advanced, and the new window correctly shows the fresh symbol as not yet complete. A release in drain mode and the reset to frame start also share one edge. The bench follows that edge with a write to symbol 0 of the next frame, and it confirms that the stale slot contents read as zero.

// File: rtl/symwin_pkg.sv
package symwin_pkg;
  // Four slots: n-1, n, n+1 in use, one more for the producer to run ahead.
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = 2;

  typedef enum logic [1:0] {
    GRP_PREV = 2'd0,
    GRP_CUR  = 2'd1,
    GRP_NEXT = 2'd2
  } grp_e;
endpackage

// File: rtl/symwin_bank.sv
module symwin_bank
  import symwin_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int DATA_W    = 16,
  parameter int SYM_W     = 8,
  parameter int USER_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           we,
  input  logic [USER_W-1:0]              wr_user,
  input  logic [SYM_W-1:0]               wr_sym,
  input  logic signed [DATA_W-1:0]       wr_data,
  input  logic [SYM_W-1:0]               cur_sym,
  input  logic [SYM_W-1:0]               rd_sym,
  input  logic [USER_W-1:0]              rd_user,
  output logic signed [DATA_W-1:0]       rd_data,
  output logic [NUM_SLOTS-1:0]           slot_full,
  output logic [NUM_SLOTS-1:0]           slot_live,
  output logic [NUM_SLOTS-1:0][SYM_W-1:0] slot_tag
);

  logic signed [DATA_W-1:0] mem [NUM_SLOTS][NUM_USERS];
  logic [SLOT_W-1:0]        wslot;
  logic [SLOT_W-1:0]        rslot;
  logic [NUM_USERS-1:0]     ubit;

  assign wslot = wr_sym[SLOT_W-1:0];
  assign rslot = rd_sym[SLOT_W-1:0];
  assign ubit  = NUM_USERS'(1) << wr_user;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [NUM_USERS-1:0] mask_q;
    logic [SYM_W-1:0]     tag_q;
    logic                 live_q;
    logic                 hit;
    logic                 claim;

    assign hit   = we && (32'(wslot) == s);
    assign claim = hit && (!live_q || (tag_q != wr_sym));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        tag_q  <= '0;
        live_q <= 1'b0;
      end else if (clr) begin
        mask_q <= '0;
        live_q <= 1'b0;
      end else if (claim) begin
        mask_q <= ubit;
        tag_q  <= wr_sym;
        live_q <= 1'b1;
      end else if (hit) begin
        mask_q <= mask_q | ubit;
      end
    end

    assign slot_full[s] = &mask_q;
    assign slot_live[s] = live_q;
    assign slot_tag[s]  = tag_q;

    // R2
    slot_reuse_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && live_q && !clr) |->
        ((tag_q != cur_sym) && (tag_q != cur_sym + SYM_W'(1)) &&
         (tag_q != cur_sym - SYM_W'(1))));
  end

  always_ff @(posedge clk) begin
    if (we && !clr) mem[wslot][wr_user] <= wr_data;
  end

  always_comb begin
    if (slot_live[rslot] && slot_full[rslot] && (slot_tag[rslot] == rd_sym))
      rd_data = mem[rslot][rd_user];
    else
      rd_data = '0;
  end

endmodule

// File: rtl/symwin_ctrl.sv
module symwin_ctrl
  import symwin_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int SYM_W     = 8,
  parameter int USER_W    = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_valid,
  input  logic [USER_W-1:0]               wr_user,
  input  logic [SYM_W-1:0]                wr_sym,
  input  logic                            flush,
  input  logic                            win_ack,
  input  logic [NUM_SLOTS-1:0]            slot_full,
  input  logic [NUM_SLOTS-1:0]            slot_live,
  input  logic [NUM_SLOTS-1:0][SYM_W-1:0] slot_tag,
  output logic [SYM_W-1:0]                cur_sym,
  output logic                            win_valid,
  output logic                            wr_ready,
  output logic                            wr_stall,
  output logic                            we,
  output logic                            clr
);

  logic [SYM_W-1:0]  cur_q;
  logic              drain_q;
  logic [SYM_W-1:0]  nxt_sym;
  logic [SYM_W-1:0]  diff;
  logic [SLOT_W-1:0] cslot;
  logic [SLOT_W-1:0] nslot;
  logic              cur_done;
  logic              nxt_done;
  logic              in_rng;
  logic              user_ok;
  logic              fire_ack;
  logic              end_frame;

  assign nxt_sym  = cur_q + SYM_W'(1);
  assign cslot    = cur_q[SLOT_W-1:0];
  assign nslot    = nxt_sym[SLOT_W-1:0];
  assign cur_done = slot_live[cslot] && slot_full[cslot] && (slot_tag[cslot] == cur_q);
  assign nxt_done = slot_live[nslot] && slot_full[nslot] && (slot_tag[nslot] == nxt_sym);

  assign diff    = wr_sym - cur_q;
  assign user_ok = 32'(wr_user) < NUM_USERS;
  assign in_rng  = (diff == SYM_W'(0)) || (diff == SYM_W'(1)) || (diff == SYM_W'(2)) ||
                   ((diff == {SYM_W{1'b1}}) && (cur_q != '0));

  assign wr_ready  = !drain_q && in_rng && user_ok;
  assign wr_stall  = wr_valid && !wr_ready;
  assign we        = wr_valid && wr_ready;
  assign win_valid = cur_done && (nxt_done || drain_q);
  assign fire_ack  = win_valid && win_ack;
  assign end_frame = fire_ack && drain_q && !nxt_done;
  assign clr       = end_frame;
  assign cur_sym   = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      if (end_frame)     cur_q <= '0;
      else if (fire_ack) cur_q <= nxt_sym;

      if (end_frame)  drain_q <= 1'b0;
      else if (flush) drain_q <= 1'b1;
    end
  end

  // R6
  win_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ack && !drain_q) |=> (cur_q == $past(cur_q) + SYM_W'(1)));

  // R6
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_valid && win_ack) |=> $stable(cur_q));

  // R7
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !(win_valid && win_ack)) |=> !wr_ready);

  // R8
  drain_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ack && drain_q && !nxt_done) |=> ((cur_q == '0) && !win_valid));

endmodule

// File: rtl/symwin_rdmux.sv
module symwin_rdmux
  import symwin_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int SYM_W     = 8,
  parameter int USER_W    = 2,
  parameter int IDX_W     = 4
) (
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [SYM_W-1:0]  cur_sym,
  output logic [SYM_W-1:0]  rd_sym,
  output logic [USER_W-1:0] rd_user,
  output logic              oob
);

  grp_e        grp;
  logic [31:0] idx;

  assign idx = 32'(rd_idx);

  always_comb begin
    grp     = GRP_PREV;
    rd_user = '0;
    oob     = 1'b0;
    if (idx < NUM_USERS) begin
      grp     = GRP_PREV;
      rd_user = USER_W'(idx);
    end else if (idx < 2 * NUM_USERS) begin
      grp     = GRP_CUR;
      rd_user = USER_W'(idx - NUM_USERS);
    end else if (idx < 3 * NUM_USERS) begin
      grp     = GRP_NEXT;
      rd_user = USER_W'(idx - 2 * NUM_USERS);
    end else begin
      oob     = 1'b1;
    end
  end

  assign rd_sym = cur_sym + SYM_W'(grp) - SYM_W'(1);

endmodule

// File: rtl/symwin_buf.sv
module symwin_buf
  import symwin_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int DATA_W    = 16,
  parameter int SYM_W     = 8,
  parameter int USER_W    = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  parameter int IDX_W     = $clog2(3 * NUM_USERS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [USER_W-1:0]        wr_user,
  input  logic [SYM_W-1:0]         wr_sym,
  input  logic signed [DATA_W-1:0] wr_data,
  output logic                     wr_stall,
  input  logic                     flush,
  output logic                     win_valid,
  input  logic                     win_ack,
  output logic [SYM_W-1:0]         win_sym,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [DATA_W-1:0] rd_data
);

  localparam int VEC_LEN = 3 * NUM_USERS;

  logic [NUM_SLOTS-1:0]            slot_full;
  logic [NUM_SLOTS-1:0]            slot_live;
  logic [NUM_SLOTS-1:0][SYM_W-1:0] slot_tag;
  logic                            we;
  logic                            clr;
  logic [SYM_W-1:0]                cur_sym;
  logic [SYM_W-1:0]                rd_sym;
  logic [USER_W-1:0]               rd_user;
  logic                            oob;
  logic signed [DATA_W-1:0]        bank_data;

  symwin_ctrl #(
    .NUM_USERS(NUM_USERS), .SYM_W(SYM_W), .USER_W(USER_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_user(wr_user), .wr_sym(wr_sym),
    .flush(flush), .win_ack(win_ack),
    .slot_full(slot_full), .slot_live(slot_live), .slot_tag(slot_tag),
    .cur_sym(cur_sym), .win_valid(win_valid),
    .wr_ready(wr_ready), .wr_stall(wr_stall), .we(we), .clr(clr)
  );

  symwin_bank #(
    .NUM_USERS(NUM_USERS), .DATA_W(DATA_W), .SYM_W(SYM_W), .USER_W(USER_W)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .we(we),
    .wr_user(wr_user), .wr_sym(wr_sym), .wr_data(wr_data),
    .cur_sym(cur_sym), .rd_sym(rd_sym), .rd_user(rd_user), .rd_data(bank_data),
    .slot_full(slot_full), .slot_live(slot_live), .slot_tag(slot_tag)
  );

  symwin_rdmux #(
    .NUM_USERS(NUM_USERS), .SYM_W(SYM_W), .USER_W(USER_W), .IDX_W(IDX_W)
  ) rdmux_i (
    .rd_idx(rd_idx), .cur_sym(cur_sym),
    .rd_sym(rd_sym), .rd_user(rd_user), .oob(oob)
  );

  assign rd_data = oob ? '0 : bank_data;
  assign win_sym = cur_sym;

  // R9
  rd_oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_idx) >= VEC_LEN) |-> (rd_data == '0));

  // R5
  first_prev_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_sym == '0) && (32'(rd_idx) < NUM_USERS)) |-> (rd_data == '0));

endmodule

// File: tb/symwin_buf_tb_top.sv
`timescale 1ns/1ps
module symwin_buf_tb_top;

  localparam int NU     = 4;
  localparam int DATA_W = 16;
  localparam int SYM_W  = 8;
  localparam int USER_W = 2;
  localparam int IDX_W  = 4;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     wr_valid = 1'b0;
  logic                     wr_ready;
  logic [USER_W-1:0]        wr_user = '0;
  logic [SYM_W-1:0]         wr_sym = '0;
  logic signed [DATA_W-1:0] wr_data = '0;
  logic                     wr_stall;
  logic                     flush = 1'b0;
  logic                     win_valid;
  logic                     win_ack = 1'b0;
  logic [SYM_W-1:0]         win_sym;
  logic [IDX_W-1:0]         rd_idx = '0;
  logic signed [DATA_W-1:0] rd_data;

  always #2 clk = ~clk;

  symwin_buf #(.NUM_USERS(NU), .DATA_W(DATA_W), .SYM_W(SYM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_user(wr_user), .wr_sym(wr_sym), .wr_data(wr_data), .wr_stall(wr_stall),
    .flush(flush), .win_valid(win_valid), .win_ack(win_ack), .win_sym(win_sym),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  typedef struct { int idx; int val; string req; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  int mdl [8][NU];

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int val(int f, int s, int u);
    return 500 * f + 10 * s + u + 1;
  endfunction

  // Monitor: drives the element index of each expected item and compares.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        rd_idx = IDX_W'(e.idx);
        #1;
        chk(int'(rd_data) == e.val, e.req, int'(rd_data), e.val);
      end
    end
  end

  task automatic wait_q();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic expect_window(int n, bit prev_zero, bit next_zero, string req);
    for (int u = 0; u < NU; u++) begin
      exp_q.push_back('{u, prev_zero ? 0 : mdl[n-1][u], prev_zero ? "R5" : req});
      exp_q.push_back('{NU + u, mdl[n][u], req});
      exp_q.push_back('{2*NU + u, next_zero ? 0 : mdl[n+1][u], req});
    end
    exp_q.push_back('{3*NU, 0, "R9"});
    exp_q.push_back('{15, 0, "R9"});
    wait_q();
  endtask

  task automatic wr(int u, int s, int d, bit acc, string req);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_user  = USER_W'(u);
    wr_sym   = SYM_W'(s);
    wr_data  = DATA_W'(d);
    #1;
    chk(wr_ready == acc, req, int'(wr_ready), int'(acc));
    chk(wr_stall == !acc, req, int'(wr_stall), int'(!acc));
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic wr_sym_all(int f, int s);
    for (int u = 0; u < NU; u++) begin
      wr(u, s, val(f, s, u), 1'b1, "R2");
      mdl[s][u] = val(f, s, u);
    end
  endtask

  task automatic ack();
    @(negedge clk);
    win_ack = 1'b1;
    @(posedge clk);
    #1;
    win_ack = 1'b0;
  endtask

  task automatic chk_win(bit v, int s, string req);
    @(negedge clk);
    #1;
    chk(win_valid == v, req, int'(win_valid), int'(v));
    chk(int'(win_sym) == s, req, int'(win_sym), s);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(win_valid == 1'b0, "R1", int'(win_valid), 0);
    chk(win_sym == '0, "R1", int'(win_sym), 0);
    chk(wr_ready == 1'b1, "R1", int'(wr_ready), 1);
    chk(wr_stall == 1'b0, "R1", int'(wr_stall), 0);

    // R3 window needs n and n+1 complete
    wr_sym_all(0, 0);
    chk_win(1'b0, 0, "R3");
    for (int u = 0; u < NU - 1; u++) begin
      wr(u, 1, val(0, 1, u), 1'b1, "R2");
      mdl[1][u] = val(0, 1, u);
    end
    chk_win(1'b0, 0, "R3");
    wr(NU - 1, 1, val(0, 1, NU - 1), 1'b1, "R2");
    mdl[1][NU-1] = val(0, 1, NU - 1);
    chk_win(1'b1, 0, "R3");

    // R4 ordering, R5 zeros before frame start, R9 out of range
    expect_window(0, 1'b1, 1'b0, "R4");

    // R2 writes outside the window are held
    wr(0, 3, 1, 1'b0, "R2");
    wr(0, 200, 1, 1'b0, "R2");
    wr_sym_all(0, 2);

    // R11 rewrite
    wr(1, 1, 777, 1'b1, "R11");
    mdl[1][1] = 777;
    chk_win(1'b1, 0, "R11");

    // R6 release
    ack();
    chk_win(1'b1, 1, "R6");
    expect_window(1, 1'b0, 1'b0, "R4 R11");

    // R10 write n+2 and release in the same cycle
    @(negedge clk);
    wr_valid = 1'b1; wr_user = 0; wr_sym = 3; wr_data = DATA_W'(val(0, 3, 0));
    win_ack = 1'b1;
    #1;
    chk(wr_ready == 1'b1, "R10", int'(wr_ready), 1);
    @(posedge clk);
    #1;
    wr_valid = 1'b0; win_ack = 1'b0;
    mdl[3][0] = val(0, 3, 0);
    chk_win(1'b0, 2, "R10");

    // R6 release without a valid window is ignored
    ack();
    chk_win(1'b0, 2, "R6");

    for (int u = 1; u < NU; u++) begin
      wr(u, 3, val(0, 3, u), 1'b1, "R2");
      mdl[3][u] = val(0, 3, u);
    end
    chk_win(1'b1, 2, "R3");
    wr(0, 4, val(0, 4, 0), 1'b1, "R2");
    wr(1, 4, val(0, 4, 1), 1'b1, "R2");

    // R7 flush and drain
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    wr(2, 4, 1, 1'b0, "R7");
    chk_win(1'b1, 2, "R7");
    expect_window(2, 1'b0, 1'b0, "R7");
    ack();
    chk_win(1'b1, 3, "R7");
    expect_window(3, 1'b0, 1'b1, "R7");

    // R8 return to frame start
    ack();
    chk_win(1'b0, 0, "R8");
    wr(0, 0, val(1, 0, 0), 1'b1, "R8");
    mdl[0][0] = val(1, 0, 0);
    for (int u = 1; u < NU; u++) begin
      wr(u, 0, val(1, 0, u), 1'b1, "R2");
      mdl[0][u] = val(1, 0, u);
    end
    wr_sym_all(1, 1);
    chk_win(1'b1, 0, "R3");
    expect_window(0, 1'b1, 1'b0, "R5");

    // R2 late write for n-1 after release
    ack();
    chk_win(1'b0, 1, "R6");
    wr(2, 0, 999, 1'b1, "R2");
    mdl[0][2] = 999;
    expect_window(1, 1'b0, 1'b1, "R2");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule